// File: doc/BRIEF.md
# Down-Counting PWM Timer

A bank of independent PWM channels, each built around a down-counter with a buffered period value and a buffered compare value. Software writes the buffers over a simple register bus, then pulses a per-channel manual-update bit to copy both buffers into the working registers before setting the run bit. While a channel runs, its counter steps down once per cycle in which that channel's tick enable is high. At zero it either reloads both working registers from the buffers, when auto-reload is set, or stops by itself. This lets software stage a new period and duty at any time and have them take effect only at a period boundary.

The count buffer holds the number of ticks per period minus one. The compare buffer holds the count value minus the number of active ticks. An all-ones compare value gives a fully active period. Each channel has an invert bit. With the bit set, the pin is high during the active phase. With it clear, the pin is active-low and idles high. The last channel has no invert bit and is always active-low. The tick enables are produced outside the block. The register bus has no wait states: a write takes effect at the clock edge on which `wr_en` is sampled high, and reads are combinational from `rd_addr`. Control and status pins stay plain, with no back-pressure.

Top module: `pwm_timer_core`

## Requirements
- R1: Byte address 0x08 is the control register. The count buffer of channel n is at 0x0C + 12·n and its compare buffer is at 0x10 + 12·n. Buffers keep the low CNT_W bits of a write and read back zero-extended. Any other address reads zero.
- R2: Control bits form one 4-bit group per channel, at bit 0 for channel 0 and at bit 4·(n+1) for channel n > 0. Within a group, bit 0 is run, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload. The last channel has no invert bit; its auto-reload bit is at group offset 2 (bit 22 for five channels). Undefined bits read zero (mask 0x007FFF0F for five channels).
- R3: While a channel's manual-update bit is set, its working counter and working compare are loaded from the buffers every clock and the counter does not step.
- R4: A running channel, with manual update clear, decrements its counter once per cycle in which its tick enable is high and holds it otherwise. A period of count value C lasts C+1 ticks.
- R5: The active phase is the set of ticks in which the counter value is greater than the compare value. With compare M, this gives C−M active ticks per period.
- R6: A compare value of all ones makes every tick of a running channel active.
- R7: When a running channel with auto-reload set is ticked at counter zero, both working registers reload from the buffers. Buffer writes made without a manual update take effect from the next period.
- R8: When a running channel with auto-reload clear is ticked at counter zero, its run bit clears itself and the output returns to its idle level. The current period completes first. A same-cycle bus write to the control register takes precedence.
- R9: With invert set, the pin equals the active phase, so it is low when idle. With invert clear, and always on the last channel, the pin is the complement of the active phase, so it is high when idle.
- R10: After reset the control register, all buffers and all working registers are zero and every pin is high.
- R11: Channels count, reload and stop independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | NUM_CH | Per-channel count enable, one bit per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | ADDR_W | Register read byte address |
| rd_data | output | 32 | Register read data, combinational |
| pwm_o | output | NUM_CH | PWM output pins, one per channel |

## Verification
The bench builds the block with its defaults: five channels and a 16-bit counter. Five channels bring the shifted last group within reach, including its relocated auto-reload bit and its missing invert bit. The 16-bit width makes the all-ones compare value 0xFFFF, so writes with upper bits set also show truncation. Duty is measured over windows that span whole periods, so the count of active samples is exact at any phase. One channel runs on a half-rate and then a frozen tick to show that the counter follows its enable.

// File: rtl/pwm_tmr_pkg.sv
`timescale 1ns/1ps
package pwm_tmr_pkg;

  localparam int unsigned BUS_W      = 32;
  localparam int unsigned CTRL_ADDR  = 8;
  localparam int unsigned BUF_BASE   = 12;
  localparam int unsigned BUF_STRIDE = 12;
  localparam int unsigned CMP_OFS    = 4;

  // Least significant bit of a channel's control group (group 1 is skipped)
  function automatic int unsigned grp_lsb(int unsigned ch);
    return (ch == 0) ? 0 : 4 * (ch + 1);
  endfunction

  // Auto-reload position: the last channel has it one place lower
  function automatic int unsigned ar_bit(int unsigned ch, int unsigned nch);
    return grp_lsb(ch) + ((ch == nch - 1) ? 2 : 3);
  endfunction

  function automatic int unsigned cnt_addr(int unsigned ch);
    return BUF_BASE + BUF_STRIDE * ch;
  endfunction

  function automatic int unsigned cmp_addr(int unsigned ch);
    return BUF_BASE + BUF_STRIDE * ch + CMP_OFS;
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_mask(int unsigned nch);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int unsigned c = 0; c < nch; c++) begin
      m[grp_lsb(c)]     = 1'b1;
      m[grp_lsb(c) + 1] = 1'b1;
      m[ar_bit(c, nch)] = 1'b1;
      if (c != nch - 1) m[grp_lsb(c) + 2] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pwm_tmr_regs.sv
`timescale 1ns/1ps
module pwm_tmr_regs
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [BUS_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [BUS_W-1:0]               rd_data,
  input  logic [NUM_CH-1:0]              stop_req,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cnt_buf,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_buf,
  output logic [NUM_CH-1:0]              ch_start,
  output logic [NUM_CH-1:0]              ch_upd,
  output logic [NUM_CH-1:0]              ch_inv,
  output logic [NUM_CH-1:0]              ch_ar
);

  localparam logic [BUS_W-1:0]  MASK   = ctrl_mask(NUM_CH);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  logic [BUS_W-1:0] ctrl_q, ctrl_d;
  logic             ctrl_wr;

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  // Bus write wins over a channel's self-stop in the same cycle
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = wr_data & MASK;
    end else begin
      for (int unsigned c = 0; c < NUM_CH; c++)
        if (stop_req[c]) ctrl_d[grp_lsb(c)] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cnt_buf <= '0;
      cmp_buf <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      for (int unsigned c = 0; c < NUM_CH; c++) begin
        if (wr_en && wr_addr == ADDR_W'(cnt_addr(c))) cnt_buf[c] <= wr_data[CNT_W-1:0];
        if (wr_en && wr_addr == ADDR_W'(cmp_addr(c))) cmp_buf[c] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CTRL) rd_data = ctrl_q;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(cnt_addr(c))) rd_data = BUS_W'(cnt_buf[c]);
      if (rd_addr == ADDR_W'(cmp_addr(c))) rd_data = BUS_W'(cmp_buf[c]);
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_fields
    localparam int unsigned LSB = grp_lsb(g);
    assign ch_start[g] = ctrl_q[LSB];
    assign ch_upd[g]   = ctrl_q[LSB + 1];
    assign ch_ar[g]    = ctrl_q[ar_bit(g, NUM_CH)];
    if (g == NUM_CH - 1) begin : g_noinv
      assign ch_inv[g] = 1'b0;
    end else begin : g_inv
      assign ch_inv[g] = ctrl_q[LSB + 2];
    end

    // R8: a channel's stop request clears its run bit unless the bus writes control
    p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req[g] && !ctrl_wr) |=> !ch_start[g]);
  end

endmodule

// File: rtl/pwm_tmr_chan.sv
`timescale 1ns/1ps
module pwm_tmr_chan #(
  parameter int unsigned CNT_W   = 16,
  parameter bit          HAS_INV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             upd,
  input  logic             inv,
  input  logic             ar,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic             stop_req,
  output logic             pwm_o
);

  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             run_tick, at_zero, active;

  assign at_zero  = (cnt_q == '0);
  assign run_tick = start && !upd && tick;
  assign stop_req = run_tick && at_zero && !ar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_buf;
      cmp_q <= cmp_buf;
    end else if (run_tick) begin
      if (!at_zero) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (ar) begin
        cnt_q <= cnt_buf;
        cmp_q <= cmp_buf;
      end
    end
  end

  assign active = start && ((&cmp_q) || (cnt_q > cmp_q));
  assign pwm_o  = (HAS_INV && inv) ? active : !active;

  p_manual_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf)));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_tick && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !(start && tick)) |=> ($stable(cnt_q) && $stable(cmp_q)));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_tick && at_zero && ar) |=> (cnt_q == $past(cnt_buf)) && (cmp_q == $past(cmp_buf)));

endmodule

// File: rtl/pwm_timer_core.sv
`timescale 1ns/1ps
module pwm_timer_core
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NUM_CH-1:0] pwm_o
);

  logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf, cmp_buf;
  logic [NUM_CH-1:0]            ch_start, ch_upd, ch_inv, ch_ar, stop_req;

  pwm_tmr_regs #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .stop_req (stop_req),
    .cnt_buf  (cnt_buf),
    .cmp_buf  (cmp_buf),
    .ch_start (ch_start),
    .ch_upd   (ch_upd),
    .ch_inv   (ch_inv),
    .ch_ar    (ch_ar)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_tmr_chan #(
      .CNT_W   (CNT_W),
      .HAS_INV (g != NUM_CH - 1)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en[g]),
      .start    (ch_start[g]),
      .upd      (ch_upd[g]),
      .inv      (ch_inv[g]),
      .ar       (ch_ar[g]),
      .cnt_buf  (cnt_buf[g]),
      .cmp_buf  (cmp_buf[g]),
      .stop_req (stop_req[g]),
      .pwm_o    (pwm_o[g])
    );
  end

endmodule

// File: tb/pwm_timer_core_bench.sv
`timescale 1ns/1ps
module pwm_timer_core_bench;

  localparam int NCH = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick2 = 1'b1;
  logic        slow2 = 1'b0;
  logic        freeze2 = 1'b0;
  logic [4:0]  tick_en;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [4:0]  pwm_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;
  logic [31:0] shadow = '0;

  always #4 clk = ~clk;

  assign tick_en = {2'b11, tick2, 2'b11};

  always @(negedge clk) begin
    if (freeze2)    tick2 <= 1'b0;
    else if (slow2) tick2 <= ~tick2;
    else            tick2 <= 1'b1;
  end

  pwm_timer_core u_pwm_timer_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pwm_o   (pwm_o)
  );

  function automatic int gb(int n);
    return (n == 0) ? 0 : 4 * (n + 1);
  endfunction
  function automatic int arb(int n);
    return gb(n) + ((n == NCH - 1) ? 2 : 3);
  endfunction
  function automatic logic [7:0] a_cnt(int n);
    return 8'(12 + 12 * n);
  endfunction
  function automatic logic [7:0] a_cmp(int n);
    return 8'(16 + 12 * n);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Caller sits at a negedge; returns at the next negedge with the write applied
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic enable_ch(input int n, input int c, input int m, input bit inv);
    wr(a_cnt(n), 32'(c));
    wr(a_cmp(n), 32'(m));
    shadow[gb(n)] = 1'b0;
    shadow[gb(n) + 1] = 1'b1;
    wr(8'd8, shadow);
    shadow[gb(n) + 1] = 1'b0;
    shadow[gb(n)] = 1'b1;
    shadow[arb(n)] = 1'b1;
    if (n != NCH - 1) shadow[gb(n) + 2] = inv;
    wr(8'd8, shadow);
  endtask

  task automatic count_high(input int n, input int samples, output int hi);
    hi = 0;
    for (int k = 0; k < samples; k++) begin
      if (pwm_o[n]) hi++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(pwm_o == 5'b11111, "R10 pins after reset", pwm_o, 5'b11111);
    rd(8'd8, d);
    chk(d == 0, "R10 control after reset", d, 0);
    rd(a_cmp(3), d);
    chk(d == 0, "R10 buffer after reset", d, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(a_cnt(2), 32'h1234ABCD);
    wr(a_cmp(3), 32'h0000_0055);
    rd(a_cnt(2), d);
    chk(d == 32'h0000ABCD, "R1 count buffer truncated readback", d, 32'hABCD);
    rd(a_cmp(3), d);
    chk(d == 32'h55, "R1 compare buffer readback", d, 32'h55);
    rd(a_cnt(1), d);
    chk(d == 0, "R1 neighbouring buffer untouched", d, 0);
    rd(8'h04, d);
    chk(d == 0, "R1 unmapped address reads zero", d, 0);
    wr(a_cnt(2), 0);
    wr(a_cmp(3), 0);
  endtask

  task automatic t_ctrl_layout;
    logic [31:0] d;
    wr(8'd8, 32'hFFFF_FFFF);
    rd(8'd8, d);
    chk(d == 32'h007FFF0F, "R2 control writable mask", d, 32'h007FFF0F);
    wr(8'd8, 32'h0);
    shadow = '0;
    @(negedge clk);
    chk(pwm_o == 5'b11111, "R9 idle pins uninverted high", pwm_o, 5'b11111);
  endtask

  task automatic t_first_period;
    logic [11:0] got, exp;
    enable_ch(0, 5, 2, 1'b1);
    for (int k = 0; k < 12; k++) begin
      got[k] = pwm_o[0];
      exp[k] = ((5 - (k % 6)) > 2);
      @(negedge clk);
    end
    chk(got == exp, "R3 R5 first periods after manual update", got, exp);
  endtask

  task automatic t_duty_and_full;
    int hi;
    enable_ch(1, 9, 6, 1'b1);
    count_high(1, 30, hi);
    chk(hi == 9, "R5 duty C=9 M=6", hi, 9);
    wr(a_cmp(1), 32'h0001_FFFF);
    repeat (12) @(negedge clk);
    count_high(1, 20, hi);
    chk(hi == 20, "R6 all-ones compare full duty", hi, 20);
    wr(a_cmp(1), 32'd6);
    repeat (12) @(negedge clk);
  endtask

  task automatic t_invert;
    int hi;
    shadow[gb(1) + 2] = 1'b0;
    wr(8'd8, shadow);
    count_high(1, 20, hi);
    chk(hi == 14, "R9 uninverted is active-low", hi, 14);
    shadow[gb(1)] = 1'b0;
    shadow[gb(3) + 2] = 1'b1;
    wr(8'd8, shadow);
    chk(pwm_o[1] == 1'b1, "R9 stopped uninverted idles high", pwm_o[1], 1);
    chk(pwm_o[3] == 1'b0, "R9 idle inverted channel low", pwm_o[3], 0);
    shadow[gb(3) + 2] = 1'b0;
    wr(8'd8, shadow);
  endtask

  task automatic t_indep;
    int h1, h3;
    enable_ch(1, 9, 6, 1'b1);
    enable_ch(3, 2, 0, 1'b1);
    h1 = 0; h3 = 0;
    for (int k = 0; k < 30; k++) begin
      if (pwm_o[1]) h1++;
      if (pwm_o[3]) h3++;
      @(negedge clk);
    end
    chk(h1 == 9,  "R11 channel 1 unaffected", h1, 9);
    chk(h3 == 20, "R11 channel 3 own duty", h3, 20);
  endtask

  task automatic t_last;
    int hi;
    logic [31:0] d;
    enable_ch(4, 3, 1, 1'b0);
    repeat (12) @(negedge clk);
    count_high(4, 16, hi);
    chk(hi == 8, "R2 R9 last channel reloads, active-low", hi, 8);
    rd(8'd8, d);
    chk(d[20] == 1'b1, "R2 last channel still running via bit 22", d[20], 1);
    chk(d[23] == 1'b0, "R2 no invert on last channel", d[23], 0);
  endtask

  task automatic t_tick;
    int hi;
    logic [9:0] s;
    slow2 = 1'b1;
    enable_ch(2, 4, 1, 1'b1);
    repeat (10) @(negedge clk);
    count_high(2, 30, hi);
    chk(hi == 18, "R4 half-rate tick doubles period", hi, 18);
    freeze2 = 1'b1;
    @(negedge clk); @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      s[k] = pwm_o[2];
      @(negedge clk);
    end
    chk(s == {10{s[0]}}, "R4 frozen tick holds output", s, {10{s[0]}});
    freeze2 = 1'b0;
    slow2 = 1'b0;
  endtask

  task automatic t_reload;
    int hi;
    wr(a_cnt(0), 32'd7);
    wr(a_cmp(0), 32'd1);
    repeat (16) @(negedge clk);
    count_high(0, 24, hi);
    chk(hi == 18, "R7 new buffers taken at period end", hi, 18);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    int waited, hi;
    shadow[arb(0)] = 1'b0;
    wr(8'd8, shadow);
    rd(8'd8, d);
    chk(d[0] == 1'b1, "R8 run bit survives clearing auto-reload", d[0], 1);
    waited = 0; hi = 0;
    while (d[0] && waited < 20) begin
      if (pwm_o[0]) hi++;
      @(negedge clk);
      waited++;
      rd(8'd8, d);
    end
    chk(waited <= 8, "R8 stop within one period", waited, 8);
    chk(d[0] == 1'b0, "R8 run bit self-cleared", d[0], 0);
    chk(hi <= 6, "R8 at most one period of active ticks", hi, 6);
    repeat (10) @(negedge clk);
    chk(pwm_o[0] == 1'b0, "R8 R9 output idle after stop", pwm_o[0], 0);
    rd(8'd8, d);
    chk(d[gb(1)] == 1'b1, "R11 other channel keeps running", d[gb(1)], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_ctrl_layout();
    t_first_period();
    t_duty_and_full();
    t_invert();
    t_indep();
    t_last();
    t_tick();
    t_reload();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=hung expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule